// File: doc/BRIEF.md
# Device status and interrupt reset register

This block is the per-device status store of an I/O adapter whose device behaviour is carried out by a slow external host. It keeps the function code of the last accepted processor command, a busy flag, an operation-complete flag, a general status field written by the host, and a small set of interrupt-level bits. Each interrupt-level bit drives its own interrupt request output.

The processor side starts a command in two execute cycles. Only the second cycle, which latches the address word, marks the device busy and captures a function code chosen by the command path. A processor sense-status command with a reset modifier clears the selected interrupt levels and the operation-complete flag locally. The interrupt requests drop in the same cycle, so the processor never waits for the host to respond.

The host side issues single-word request codes and gets one response word back on the following cycle. Read-and-clear polls return the value held before they clear it. A host that polls late therefore neither misses a command nor undoes a reset.

Top module: `dev_status_reg`

## Requirements
- R1: Interrupt-level bit k is readable at stat_o[k] (k below NLEV) and drives irq_o[k]. irq_o[k] is also forced low in any cycle where a sense reset selects bit k.
- R2: With sense_rst_i high, every level whose sense_mod_i bit is set drops on irq_o in that same cycle, and its stored bit is zero after the clock edge.
- R3: Host code 13 returns the level bits in host_rdata_o[NLEV-1:0], upper bits zero, and clears all level bits.
- R4: Operation-complete at stat_o[STAT_W-2] is set by a host status write (code 2) with wdata bit STAT_W-2 high. A write with that bit low leaves it unchanged. Any sense reset clears it.
- R5: Host code 1 returns in host_rdata_o[FUNC_W-1:0] the function code held before the request, upper bits zero, and leaves the stored code at zero.
- R6: Busy at stat_o[STAT_W-1] is set by exec2_i only if exec1_i was seen since the last exec2_i. exec1_i alone, or exec2_i without a preceding exec1_i, changes neither busy nor the function code.
- R7: The function code stored on busy is cmd_path_i + 1, taken from the path and not from any data word.
- R8: Each cycle with host_req_i high is followed in the next cycle by exactly one cycle of host_rvalid_o. Code 3 returns the status word as it stood before the request. Code 2 and unknown codes return zero, and unknown codes change nothing.
- R9: When a set and a clear of the same bit fall in one cycle, the clear wins. This applies to levels, operation-complete, busy and the function code.
- R10: A host status write loads stat_o[STAT_W-3:NLEV] from the matching wdata bits, loads busy from wdata bit STAT_W-1, and ORs wdata[NLEV-1:0] into the level bits.
- R11: After reset, the status word, function code, interrupt requests and host_rvalid_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| exec1_i | input | 1 | First execute cycle of a processor command |
| exec2_i | input | 1 | Second execute cycle, address word latched |
| cmd_path_i | input | PATH_W | Command path that issued the command |
| sense_rst_i | input | 1 | Sense-status command with reset modifier |
| sense_mod_i | input | NLEV | Per-level reset modifier bits |
| host_req_i | input | 1 | Host request strobe |
| host_op_i | input | 4 | Host request code |
| host_wdata_i | input | STAT_W | Host write word |
| host_rvalid_o | output | 1 | Host response valid |
| host_rdata_o | output | STAT_W | Host response word |
| stat_o | output | STAT_W | Current status word |
| irq_o | output | NLEV | Interrupt requests, one per level |

## Verification
The bench builds the block with NLEV=3, STAT_W=16, FUNC_W=3 and NPATH=4. With these values every command path maps to a distinct non-zero function code, so a cleared code is always distinguishable from a captured one. Every level bit can be set, masked and polled on its own. Busy, operation-complete and the general field fit at the top of a 16-bit word. These small values let random traffic reach each same-cycle set/clear collision many times.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  localparam logic [3:0] HOP_FUNC_RC = 4'd1;
  localparam logic [3:0] HOP_STAT_WR = 4'd2;
  localparam logic [3:0] HOP_STAT_RD = 4'd3;
  localparam logic [3:0] HOP_LVL_RC  = 4'd13;
endpackage

// File: rtl/dsr_lvl_bank.sv
module dsr_lvl_bank #(
  parameter int NLEV = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NLEV-1:0] set_i,
  input  logic [NLEV-1:0] clr_i,
  input  logic [NLEV-1:0] imm_clr_i,
  output logic [NLEV-1:0] lvl_o,
  output logic [NLEV-1:0] irq_o
);
  logic [NLEV-1:0] lvl_q;

  for (genvar k = 0; k < NLEV; k++) begin : g_lvl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        lvl_q[k] <= 1'b0;
      else if (clr_i[k])  lvl_q[k] <= 1'b0;
      else if (set_i[k])  lvl_q[k] <= 1'b1;
    end
    // processor reset masks the request in the same cycle
    assign irq_o[k] = lvl_q[k] & ~imm_clr_i[k];
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/dsr_cmd_track.sv
module dsr_cmd_track #(
  parameter int FUNC_W = 3,
  parameter int PATH_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exec1_i,
  input  logic              exec2_i,
  input  logic [PATH_W-1:0] path_i,
  input  logic              busy_set_i,
  input  logic              busy_clr_i,
  input  logic              fcode_clr_i,
  output logic              busy_o,
  output logic [FUNC_W-1:0] fcode_o
);
  logic              pend_q, busy_q;
  logic [FUNC_W-1:0] fcode_q;
  logic              accept;

  assign accept = exec2_i & pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      busy_q  <= 1'b0;
      fcode_q <= '0;
    end else begin
      if (exec2_i)      pend_q <= 1'b0;
      else if (exec1_i) pend_q <= 1'b1;

      if (busy_clr_i)                   busy_q <= 1'b0;
      else if (accept || busy_set_i)    busy_q <= 1'b1;

      if (fcode_clr_i)  fcode_q <= '0;
      else if (accept)  fcode_q <= FUNC_W'(path_i) + FUNC_W'(1);
    end
  end

  assign busy_o  = busy_q;
  assign fcode_o = fcode_q;
endmodule

// File: rtl/dsr_host_port.sv
module dsr_host_port #(
  parameter int STAT_W = 16,
  parameter int NLEV   = 3,
  parameter int FUNC_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [3:0]        op_i,
  input  logic [STAT_W-1:0] stat_i,
  input  logic [NLEV-1:0]   lvl_i,
  input  logic [FUNC_W-1:0] fcode_i,
  output logic              wr_o,
  output logic              func_rc_o,
  output logic              lvl_rc_o,
  output logic              rvalid_o,
  output logic [STAT_W-1:0] rdata_o
);
  import dsr_pkg::*;

  logic [STAT_W-1:0] resp;
  logic              rvalid_q;
  logic [STAT_W-1:0] rdata_q;

  assign wr_o      = req_i && (op_i == HOP_STAT_WR);
  assign func_rc_o = req_i && (op_i == HOP_FUNC_RC);
  assign lvl_rc_o  = req_i && (op_i == HOP_LVL_RC);

  always_comb begin
    resp = '0;
    unique case (op_i)
      HOP_FUNC_RC: resp[FUNC_W-1:0] = fcode_i;
      HOP_STAT_RD: resp = stat_i;
      HOP_LVL_RC:  resp[NLEV-1:0] = lvl_i;
      default:     resp = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= req_i;
      if (req_i) rdata_q <= resp;
    end
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;
endmodule

// File: rtl/dev_status_reg.sv
module dev_status_reg #(
  parameter int NLEV   = 3,
  parameter int STAT_W = 16,
  parameter int FUNC_W = 3,
  parameter int NPATH  = 4,
  localparam int PATH_W = (NPATH > 1) ? $clog2(NPATH) : 1,
  localparam int GEN_W  = STAT_W - 2 - NLEV
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exec1_i,
  input  logic              exec2_i,
  input  logic [PATH_W-1:0] cmd_path_i,
  input  logic              sense_rst_i,
  input  logic [NLEV-1:0]   sense_mod_i,
  input  logic              host_req_i,
  input  logic [3:0]        host_op_i,
  input  logic [STAT_W-1:0] host_wdata_i,
  output logic              host_rvalid_o,
  output logic [STAT_W-1:0] host_rdata_o,
  output logic [STAT_W-1:0] stat_o,
  output logic [NLEV-1:0]   irq_o
);
  localparam int BUSY_B = STAT_W - 1;
  localparam int OPC_B  = STAT_W - 2;

  logic              wr, func_rc, lvl_rc;
  logic [NLEV-1:0]   lvl, lvl_set, lvl_clr, sense_clr;
  logic              busy;
  logic [FUNC_W-1:0] fcode;
  logic              opc_q;
  logic [GEN_W-1:0]  gen_q;

  assign sense_clr = sense_rst_i ? sense_mod_i : '0;
  assign lvl_clr   = sense_clr | (lvl_rc ? '1 : '0);
  assign lvl_set   = wr ? host_wdata_i[NLEV-1:0] : '0;

  dsr_lvl_bank #(.NLEV(NLEV)) u_lvl (
    .clk_i, .rst_ni,
    .set_i(lvl_set), .clr_i(lvl_clr), .imm_clr_i(sense_clr),
    .lvl_o(lvl), .irq_o(irq_o)
  );

  dsr_cmd_track #(.FUNC_W(FUNC_W), .PATH_W(PATH_W)) u_cmd (
    .clk_i, .rst_ni,
    .exec1_i, .exec2_i, .path_i(cmd_path_i),
    .busy_set_i(wr & host_wdata_i[BUSY_B]),
    .busy_clr_i(wr & ~host_wdata_i[BUSY_B]),
    .fcode_clr_i(func_rc),
    .busy_o(busy), .fcode_o(fcode)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opc_q <= 1'b0;
      gen_q <= '0;
    end else begin
      if (sense_rst_i)                    opc_q <= 1'b0;
      else if (wr && host_wdata_i[OPC_B]) opc_q <= 1'b1;
      if (wr) gen_q <= host_wdata_i[OPC_B-1:NLEV];
    end
  end

  assign stat_o = {busy, opc_q, gen_q, lvl};

  dsr_host_port #(.STAT_W(STAT_W), .NLEV(NLEV), .FUNC_W(FUNC_W)) u_host (
    .clk_i, .rst_ni,
    .req_i(host_req_i), .op_i(host_op_i),
    .stat_i(stat_o), .lvl_i(lvl), .fcode_i(fcode),
    .wr_o(wr), .func_rc_o(func_rc), .lvl_rc_o(lvl_rc),
    .rvalid_o(host_rvalid_o), .rdata_o(host_rdata_o)
  );
endmodule

// File: rtl/dsr_checker.sv
module dsr_checker #(
  parameter int NLEV   = 3,
  parameter int STAT_W = 16,
  parameter int FUNC_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              exec1_i,
  input logic              exec2_i,
  input logic              sense_rst_i,
  input logic [NLEV-1:0]   sense_mod_i,
  input logic              host_req_i,
  input logic [3:0]        host_op_i,
  input logic              host_rvalid_o,
  input logic [STAT_W-1:0] host_rdata_o,
  input logic [STAT_W-1:0] stat_o,
  input logic [NLEV-1:0]   irq_o,
  input logic [FUNC_W-1:0] fcode
);
  assert_irq_mask_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sense_rst_i |-> ((irq_o & sense_mod_i) == '0));

  assert_lvl_poll_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_req_i && host_op_i == 4'd13) |=> (stat_o[NLEV-1:0] == '0));

  assert_opc_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sense_rst_i |=> !stat_o[STAT_W-2]);

  assert_func_poll_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_req_i && host_op_i == 4'd1) |=>
      (host_rdata_o[FUNC_W-1:0] == $past(fcode) && fcode == '0));

  assert_busy_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_o[STAT_W-1]) |-> ($past(exec2_i) || $past(host_req_i)));

  assert_exec1_no_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec1_i && !exec2_i && !host_req_i && !stat_o[STAT_W-1]) |=> !stat_o[STAT_W-1]);

  assert_rvalid_follows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_req_i |=> host_rvalid_o);

  assert_rvalid_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_req_i |=> !host_rvalid_o);

  assert_irq_from_lvl_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_o & ~stat_o[NLEV-1:0]) == '0));
endmodule

bind dev_status_reg dsr_checker #(.NLEV(NLEV), .STAT_W(STAT_W), .FUNC_W(FUNC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .exec1_i(exec1_i), .exec2_i(exec2_i),
  .sense_rst_i(sense_rst_i), .sense_mod_i(sense_mod_i),
  .host_req_i(host_req_i), .host_op_i(host_op_i),
  .host_rvalid_o(host_rvalid_o), .host_rdata_o(host_rdata_o),
  .stat_o(stat_o), .irq_o(irq_o), .fcode(fcode)
);

// File: tb/dev_status_reg_test.sv
module dev_status_reg_test;
  localparam int NLEV = 3, STAT_W = 16, FUNC_W = 3, NPATH = 4, PATH_W = 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic exec1, exec2, srst, hreq;
  logic [PATH_W-1:0] path;
  logic [NLEV-1:0] smod;
  logic [3:0] hop;
  logic [STAT_W-1:0] hwd, rdata, stat;
  logic rvalid;
  logic [NLEV-1:0] irq;

  always #4 clk = ~clk;

  dev_status_reg #(.NLEV(NLEV), .STAT_W(STAT_W), .FUNC_W(FUNC_W), .NPATH(NPATH)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .exec1_i(exec1), .exec2_i(exec2), .cmd_path_i(path),
    .sense_rst_i(srst), .sense_mod_i(smod), .host_req_i(hreq), .host_op_i(hop),
    .host_wdata_i(hwd), .host_rvalid_o(rvalid), .host_rdata_o(rdata),
    .stat_o(stat), .irq_o(irq));

  int checks = 0, fails = 0;
  // model state
  logic m_busy, m_opc, m_pend;
  logic [10:0] m_gen;
  logic [NLEV-1:0] m_lvl;
  logic [FUNC_W-1:0] m_fc;

  function automatic logic [STAT_W-1:0] m_stat();
    return {m_busy, m_opc, m_gen, m_lvl};
  endfunction

  function automatic logic [STAT_W-1:0] m_resp(logic [3:0] op);
    case (op)
      4'd1:    return {{(STAT_W-FUNC_W){1'b0}}, m_fc};
      4'd3:    return m_stat();
      4'd13:   return {{(STAT_W-NLEV){1'b0}}, m_lvl};
      default: return '0;
    endcase
  endfunction

  task automatic chk(string tag, logic [STAT_W-1:0] act, logic [STAT_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    exec1 = 0; exec2 = 0; path = '0; srst = 0; smod = '0;
    hreq = 0; hop = '0; hwd = '0;
  endtask

  // one cycle: inputs already driven; checks irq, then edge, then outputs
  task automatic step(string tag);
    logic [NLEV-1:0] sclr, lclr, lset;
    logic wr, frc, lrc, acc;
    logic [STAT_W-1:0] exp_r;
    logic exp_v;
    #1;
    sclr = srst ? smod : '0;
    chk({tag, " R1 irq"}, STAT_W'(irq), STAT_W'(m_lvl & ~sclr));
    wr = hreq && hop == 4'd2; frc = hreq && hop == 4'd1; lrc = hreq && hop == 4'd13;
    exp_v = hreq;
    exp_r = hreq ? m_resp(hop) : rdata;
    lclr = sclr | (lrc ? '1 : '0);
    lset = wr ? hwd[NLEV-1:0] : '0;
    acc = exec2 && m_pend;
    @(posedge clk);
    m_lvl = (m_lvl | lset) & ~lclr;
    if (srst) m_opc = 0; else if (wr && hwd[14]) m_opc = 1;
    if (wr) m_gen = hwd[13:3];
    if (wr && !hwd[15]) m_busy = 0; else if (acc || (wr && hwd[15])) m_busy = 1;
    if (frc) m_fc = '0; else if (acc) m_fc = FUNC_W'(path) + 3'd1;
    if (exec2) m_pend = 0; else if (exec1) m_pend = 1;
    #2;
    chk({tag, " R8 rvalid"}, STAT_W'(rvalid), STAT_W'(exp_v));
    if (exp_v) chk({tag, " R8 rdata"}, rdata, exp_r);
    chk({tag, " R10 stat"}, stat, m_stat());
    idle();
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5a7));
    idle();
    m_busy = 0; m_opc = 0; m_pend = 0; m_gen = '0; m_lvl = '0; m_fc = '0;
    repeat (3) @(posedge clk);
    #2;
    chk("R11 stat", stat, '0);
    chk("R11 irq", STAT_W'(irq), '0);
    chk("R11 rvalid", STAT_W'(rvalid), '0);
    rst_ni = 1;
    @(posedge clk); #2;

    // R6: exec1 alone, then exec2 without pending
    exec1 = 1; path = 2'd2; step("R6 exec1 only");
    chk("R6 no busy after exec1", STAT_W'(stat[15]), 0);
    exec2 = 1; path = 2'd1; step("R7 accept");
    chk("R7 fcode path1", STAT_W'(stat[15]), 1);
    hreq = 1; hop = 4'd1; step("R5 poll");
    chk("R5 rdata=2", rdata, 16'd2);
    hreq = 1; hop = 4'd1; step("R5 repoll");
    chk("R5 cleared", rdata, 16'd0);
    hreq = 1; hop = 4'd2; hwd = 16'h0000; step("R10 clr busy");
    exec2 = 1; path = 2'd3; step("R6 exec2 no exec1");
    chk("R6 stays idle", STAT_W'(stat[15]), 0);
    // R3/R4: set levels + opc, sense partial mask, poll rest
    hreq = 1; hop = 4'd2; hwd = 16'h4007; step("R4 set opc");
    srst = 1; smod = 3'b010; step("R2 mask lvl1");
    chk("R2 lvl", STAT_W'(stat[2:0]), 16'd5);
    chk("R4 opc cleared", STAT_W'(stat[14]), 0);
    hreq = 1; hop = 4'd13; step("R3 lvl poll");
    chk("R3 rdata", rdata, 16'd5);
    // R9 collisions
    hreq = 1; hop = 4'd2; hwd = 16'h4007; srst = 1; smod = 3'b111; step("R9 lvl/opc");
    chk("R9 clear wins", STAT_W'(stat[14:0] & 16'h4007), 0);
    exec1 = 1; step("R9 arm");
    exec2 = 1; path = 2'd0; hreq = 1; hop = 4'd1; step("R9 fcode");
    hreq = 1; hop = 4'd1; step("R9 fcode zero");
    chk("R9 fcode cleared", rdata, 0);
    exec1 = 1; step("R9 arm2");
    exec2 = 1; hreq = 1; hop = 4'd2; hwd = 16'h0000; step("R9 busy");
    chk("R9 busy clear wins", STAT_W'(stat[15]), 0);
    hreq = 1; hop = 4'd9; step("R8 unknown");
    chk("R8 unknown zero", rdata, 0);

    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 2) exec1 = 1; else if (r < 4) exec2 = 1;
      path = PATH_W'($urandom);
      if ($urandom_range(0, 4) == 0) begin srst = 1; smod = NLEV'($urandom); end
      if ($urandom_range(0, 2) == 0) begin
        hreq = 1;
        case ($urandom_range(0, 4))
          0: hop = 4'd1; 1: hop = 4'd2; 2: hop = 4'd3; 3: hop = 4'd13;
          default: hop = 4'($urandom);
        endcase
        hwd = STAT_W'($urandom);
      end
      step("rand");
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule